// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner among N requesters in the same cycle in which the requests are presented. It keeps a pairwise precedence bit for every pair of requesters. Only the lower triangle of the precedence matrix is stored. For a pair with hi > lo, the bit is 1 when hi outranks lo, and 0 when lo outranks hi.

A requester is knocked out when any other active requester outranks it. Whichever requester is not knocked out wins. On the clock edge after a grant, the winner drops below every other requester. The other pairwise relations stay as they were. The resulting order is always the least-recently-served order.

The arbiter serves resources such as a crossbar output port or a virtual channel. In those uses the requester count is small and each requester must be served fairly. Reset loads the order in which a lower index outranks a higher one.

Top module: `lrs_matrix_arb`

## Requirements
- R1: A grant bit is high only when the request bit at the same position is high.
- R2: At most one grant bit is high in any cycle.
- R3: Whenever at least one request bit is high, exactly one grant bit is high in that same cycle, with no register between `req` and `gnt`.
- R4: After reset, precedence follows index order, with requester 0 the highest and requester N-1 the lowest.
- R5: The requester granted in a cycle is the lowest-ranked requester in the next cycle. If it requests again together with any other requester, it loses.
- R6: A cycle with no request bit high issues no grant and leaves the precedence order unchanged.
- R7: Among active requesters, the winner is the one served least recently. Requesters never served since reset rank by index order. For example, after single grants to 2, 1 and then 0, the request pattern {0,1,2} held steady is granted in the sequence 2, 1, 0, 2.
- R8: A requester that keeps its request high is granted before N grants go to other requesters. In other words, it waits at most N-1 grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| req | input | N | Request vector, bit i for requester i |
| gnt | output | N | Grant vector, zero or one-hot, combinational from req |

## Verification
The hardest case to reach from the ports is a requester that waits the full N-1 grants. To get there, every other requester must be ranked above it and must also keep requesting while it waits. The stimulus first forces a known order with single-requester grants. It then runs a long pseudo-random phase in which one requester stays permanently asserted while the others toggle. A reference model that keeps a served-order list tracks the expected winner every cycle. A separate wait counter measures the longest stall of each requester.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

  // Flat position of the precedence bit for the pair (hi, lo), hi > lo.
  function automatic int tri_idx(input int hi, input int lo);
    return ((hi * (hi - 1)) / 2) + lo;
  endfunction

endpackage

// File: rtl/lrs_prio_state.sv
module lrs_prio_state
  import lrs_arb_pkg::*;
#(
  parameter int N = 4,
  localparam int TRI_W = (N * (N - 1)) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     gnt,
  output logic [TRI_W-1:0] prio_q
);

  logic [TRI_W-1:0] prio_d;
  logic             upd_en;

  // The winner loses every pair it belongs to; other pairs hold.
  always_comb begin
    prio_d = prio_q;
    for (int hi = 1; hi < N; hi++) begin
      for (int lo = 0; lo < hi; lo++) begin
        if (gnt[hi]) begin
          prio_d[tri_idx(hi, lo)] = 1'b0;
        end else if (gnt[lo]) begin
          prio_d[tri_idx(hi, lo)] = 1'b1;
        end
      end
    end
  end

  assign upd_en = |gnt;

  // All zero means each lower index outranks each higher index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (upd_en) begin
      prio_q <= prio_d;
    end
  end

endmodule

// File: rtl/lrs_grant_logic.sv
module lrs_grant_logic
  import lrs_arb_pkg::*;
#(
  parameter int N = 4,
  localparam int TRI_W = (N * (N - 1)) / 2
) (
  input  logic [N-1:0]     req,
  input  logic [TRI_W-1:0] prio,
  output logic [N-1:0]     gnt
);

  logic [N-1:0] kill;

  // kill[me] is the OR over a column of (active request AND outranks me).
  always_comb begin
    kill = '0;
    for (int me = 0; me < N; me++) begin
      for (int oth = 0; oth < N; oth++) begin
        if (oth > me) begin
          if (req[oth] && prio[tri_idx(oth, me)]) kill[me] = 1'b1;
        end else if (oth < me) begin
          if (req[oth] && !prio[tri_idx(me, oth)]) kill[me] = 1'b1;
        end
      end
    end
  end

  assign gnt = req & ~kill;

endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  localparam int TRI_W = (N * (N - 1)) / 2;

  logic [TRI_W-1:0] prio_q;

  lrs_grant_logic #(.N(N)) u_grant (
    .req  (req),
    .prio (prio_q),
    .gnt  (gnt)
  );

  lrs_prio_state #(.N(N)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .gnt    (gnt),
    .prio_q (prio_q)
  );

endmodule

// File: rtl/lrs_matrix_arb_chk.sv
module lrs_matrix_arb_chk #(
  parameter int N = 4,
  localparam int TRI_W = (N * (N - 1)) / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req,
  input logic [N-1:0]     gnt,
  input logic [TRI_W-1:0] prio
);

  logic [7:0] wait_q [N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_req
      // Grants to others while requester k keeps asking and is not served.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wait_q[k] <= '0;
        end else if (!req[k] || gnt[k]) begin
          wait_q[k] <= '0;
        end else if ((|gnt) && (wait_q[k] != 8'hFF)) begin
          wait_q[k] <= wait_q[k] + 8'd1;
        end
      end

      p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wait_q[k]) <= N - 1);

      p_winner_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[k] |=> !(gnt[k] && ($countones(req) > 1)));
    end
  endgenerate

  p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_work_conserving_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  p_idle_holds_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(prio));

endmodule

bind lrs_matrix_arb lrs_matrix_arb_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .gnt   (gnt),
  .prio  (prio_q)
);

// File: tb/lrs_matrix_arb_bench.sv
module lrs_matrix_arb_bench;

  localparam int N  = 4;
  localparam int NV = 12;

  // Each entry: {req[3:0], expected gnt[3:0]}, applied right after reset.
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'hF1, 8'hF2, 8'h31, 8'hA8, 8'h00,
    8'hB2, 8'h44, 8'hE8, 8'hF1, 8'h98, 8'h54
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] gnt;

  int n_chk;
  int n_bad;
  bit done;
  int order [N];
  int waitc [N];

  lrs_matrix_arb #(.N(N)) u_lrs_matrix_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected=%b (req=%b)", tag, got, exp, req);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) order[i] = i;
    for (int i = 0; i < N; i++) waitc[i] = 0;
  endtask

  function automatic logic [N-1:0] model_grant(input logic [N-1:0] r);
    for (int p = 0; p < N; p++) begin
      if (r[order[p]]) return N'(1) << order[p];
    end
    return '0;
  endfunction

  task automatic model_update(input logic [N-1:0] g);
    int k;
    int pos;
    k = -1;
    pos = 0;
    for (int i = 0; i < N; i++) if (g[i]) k = i;
    if (k >= 0) begin
      for (int p = 0; p < N; p++) if (order[p] == k) pos = p;
      for (int p = pos; p < N - 1; p++) order[p] = order[p + 1];
      order[N - 1] = k;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Drive at a falling edge, sample 1 ns later, register updates at the rising edge.
  task automatic step(input string tag, input logic [N-1:0] r);
    logic [N-1:0] e;
    @(negedge clk);
    req = r;
    #1;
    e = model_grant(r);
    check(tag, gnt, e);
    model_update(e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: gnt=%b expected=done", gnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [N-1:0] r;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    req   = '0;
    model_reset();

    // R4: reset state, requester 0 first, no grant on idle.
    do_reset();
    #1;
    check("R4 idle after reset", gnt, 4'b0000);
    req = 4'b1111;
    #1;
    check("R4 all requesting after reset", gnt, 4'b0001);
    req = 4'b1100;
    #1;
    check("R4 index order 2 over 3", gnt, 4'b0100);

    // Table walk (R5, R6, R7): fixed stimulus with hand-computed winners.
    do_reset();
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req = VEC[v][7:4];
      #1;
      check($sformatf("R7 table vector %0d", v), gnt, VEC[v][3:0]);
      model_update(VEC[v][3:0]);
    end

    // R7: the three-requester sequence from a forced order 3,2,1,0.
    do_reset();
    step("R7 prep grant 2", 4'b0100);
    step("R7 prep grant 1", 4'b0010);
    step("R7 prep grant 0", 4'b0001);
    @(negedge clk); req = 4'b0111; #1; check("R7 seq 1st", gnt, 4'b0100);
    @(negedge clk); #1; check("R7 seq 2nd", gnt, 4'b0010);
    @(negedge clk); #1; check("R7 seq 3rd", gnt, 4'b0001);
    @(negedge clk); #1; check("R7 seq 4th", gnt, 4'b0100);
    model_update(4'b0100);
    model_update(4'b0010);
    model_update(4'b0001);
    model_update(4'b0100);

    // R6: a run of idle cycles leaves the order where it was.
    step("R6 idle a", 4'b0000);
    step("R6 idle b", 4'b0000);
    step("R6 idle c", 4'b0000);
    step("R6 order kept after idle", 4'b1111);

    // R5: the winner immediately loses a two-way contest.
    step("R5 single grant 3", 4'b1000);
    step("R5 3 loses to 0", 4'b1001);

    // R8, R1, R2, R3: long pseudo-random run, requester 3 held high.
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[3:0];
      if (c < 2000) r[3] = 1'b1;
      step("R7 random vs model", r);
      if ((gnt & ~r) != '0) check("R1 grant without request", gnt, gnt & r);
      if ((r != '0) && ($countones(gnt) != 1)) check("R3 work conserving", gnt, model_grant(r));
      if ($countones(gnt) > 1) check("R2 at most one grant", gnt, model_grant(r));
      for (int i = 0; i < N; i++) begin
        if (!r[i] || gnt[i]) waitc[i] = 0;
        else if (gnt != '0) waitc[i]++;
        if (waitc[i] > N - 1) begin
          n_chk++;
          n_bad++;
          $display("FAIL R8: requester %0d waited %0d expected <= %0d", i, waitc[i], N - 1);
        end
      end
    end
    n_chk++;

    // R4: reset in the middle of traffic restores index order.
    do_reset();
    step("R4 order after mid-run reset", 4'b1110);
    step("R4 next after mid-run reset", 4'b1100);

    @(negedge clk);
    req = '0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule